// File: doc/BRIEF.md
# DDR3 Read Calibration Controller

This block runs the read-side calibration of a DDR3 interface one byte lane at a time. Each lane is an 8-bit data group with its own DQS strobe. Skew across the module is taken to be under two bit times. When a `start` pulse arrives, the controller first asks an external agent to load the DRAM array with random data. It then goes through the lanes in ascending order.

For each lane, the controller resets the lane's input delay and reads the write-leveling sample. If the sample shows the clock already high at the DQS transition with no added delay, the lane is late by more than one bit time. A delay element can only add latency, so it cannot pull such a lane back. In that case the controller asks the PHY to move the DQS edge into the clock-low region and to apply one read bitslip, which removes a whole bit of lag.

Next, the controller reads the same address repeatedly, raising the input delay one tap at a time until a run of matching reads is seen. If the highest tap is reached without such a run, the lane is marked failed and the controller moves on. After the last lane, it pulses `done` and holds the result of every lane on its status outputs.

Top module: `rdcal_ctrl`

## Requirements
- R1: During and after reset, every request and strobe output, `busy`, `done` and all status outputs are 0.
- R2: A `start` pulse while idle raises `fill_req`, which stays high until `fill_ack` is seen, before any lane work begins. A `start` seen while `busy` is high has no effect on the sequence or the results.
- R3: Lanes are calibrated in order 0 to LANES-1. Each lane begins with a `dly_rst` that is one cycle wide, with `lane_sel` showing the lane.
- R4: `lvl_sample` is read in the cycle after `dly_rst`. If it is 1, `dqs_req` stays high until `dqs_ack`, then `slip_req` stays high until `slip_ack`, and then reads begin. If it is 0, reads begin at once. `lane_slip` of the lane records which path was taken.
- R5: `rd_req` stays high during the sweep, and each cycle with both `rd_req` and `rd_ack` high completes one read. When CONSIST_N reads in a row report `rd_match`=1, the lane passes at its current tap.
- R6: A read with `rd_match`=0 below the top tap clears the run count. It then causes a `dly_inc` one cycle wide, which raises the tap by one, followed by `rd_req` in the next cycle.
- R7: A mismatching read at the top tap (2^TAP_W-1, 31 by default) sets the lane's fail flag and ends the lane. A lane never sees more than 2^TAP_W-1 `dly_inc` pulses after its `dly_rst`.
- R8: Accepting `start` clears all status. After each lane finishes, its slip flag, final tap (`lane_tap` bits [TAP_W*i +: TAP_W] for lane i) and fail flag are held until the next accepted `start`.
- R9: After the last lane, `done` pulses for one cycle and `busy` is 0 in the following cycle.
- R10: At most one of `fill_req`, `dly_rst`, `dqs_req`, `slip_req`, `rd_req`, `dly_inc` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration pass |
| fill_req | output | 1 | Request random fill of the DRAM array |
| fill_ack | input | 1 | Fill finished |
| lane_sel | output | clog2(LANES) | Lane being calibrated |
| dly_rst | output | 1 | Reset the input delay of the selected lane to tap 0 |
| lvl_sample | input | 1 | Leveling sample: clock high at the DQS transition |
| dqs_req | output | 1 | Request that the DQS edge move into the clock-low region |
| dqs_ack | input | 1 | DQS move finished |
| slip_req | output | 1 | Request one read bitslip from the pulse sequencer |
| slip_ack | input | 1 | Bitslip applied |
| dly_inc | output | 1 | Raise the input delay of the selected lane by one tap |
| rd_req | output | 1 | Request a read of the test address |
| rd_ack | input | 1 | Read completed this cycle |
| rd_match | input | 1 | Completed read matched the previous data |
| busy | output | 1 | Calibration pass in progress |
| done | output | 1 | Pass finished, one-cycle pulse |
| lane_slip | output | LANES | Per-lane bitslip-used flag |
| lane_tap | output | LANES*TAP_W | Per-lane final delay tap |
| lane_fail | output | LANES | Per-lane failure flag |

## Verification
The assertions assume that each acknowledge arrives only while its own request is high. They also assume that `rd_match` has meaning only in a cycle with `rd_ack`. The stimulus keeps to this: the bench raises every acknowledge for one cycle, only against a request it has just seen, after a delay of zero to two cycles. Outside the cycle in which it is sampled, `lvl_sample` is driven with toggling junk, and `rd_match` is junk whenever there is no read acknowledge. This shows that the controller ignores both inputs at those times.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FILL,
      ST_RST,
      ST_LVL,
      ST_DQSMV,
      ST_SLIP,
      ST_READ,
      ST_INC,
      ST_NEXT,
      ST_DONE
   } cal_st_e;

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rdcal_seq.sv
module rdcal_seq
   import rdcal_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              fill_ack,
   input  logic              lvl_sample,
   input  logic              dqs_ack,
   input  logic              slip_ack,
   input  logic              sw_pass,
   input  logic              sw_fail,
   input  logic              sw_retry,
   output cal_st_e           st,
   output logic [LANE_W-1:0] lane,
   output logic              slip_used
);

   localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

   cal_st_e st_nx;
   logic    lane_last;

   assign lane_last = (lane == LAST_LANE);

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (start) st_nx = ST_FILL;
         ST_FILL:  if (fill_ack) st_nx = ST_RST;
         ST_RST:   st_nx = ST_LVL;
         ST_LVL:   st_nx = lvl_sample ? ST_DQSMV : ST_READ;
         ST_DQSMV: if (dqs_ack) st_nx = ST_SLIP;
         ST_SLIP:  if (slip_ack) st_nx = ST_READ;
         ST_READ: begin
            if (sw_pass || sw_fail) st_nx = ST_NEXT;
            else if (sw_retry)      st_nx = ST_INC;
         end
         ST_INC:   st_nx = ST_READ;
         ST_NEXT:  st_nx = lane_last ? ST_DONE : ST_RST;
         ST_DONE:  st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         lane      <= '0;
         slip_used <= 1'b0;
      end else begin
         st <= st_nx;
         if (st == ST_IDLE && start)
            lane <= '0;
         else if (st == ST_NEXT && !lane_last)
            lane <= lane + 1'b1;
         if (st == ST_RST)
            slip_used <= 1'b0;
         else if (st == ST_LVL && lvl_sample)
            slip_used <= 1'b1;
      end
   end

endmodule

// File: rtl/rdcal_sweep.sv
module rdcal_sweep #(
   parameter int TAP_W     = 5,
   parameter int CONSIST_N = 16,
   parameter int CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             rd_done,
   input  logic             rd_match,
   output logic [TAP_W-1:0] tap,
   output logic             fail_q,
   output logic             pass,
   output logic             fail,
   output logic             retry
);

   localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(CONSIST_N - 1);

   logic [CNT_W-1:0] run_cnt;
   logic             at_top;
   logic             run_full;

   assign at_top   = &tap;
   assign run_full = (run_cnt == RUN_LAST);
   assign pass     = rd_done &&  rd_match && run_full;
   assign fail     = rd_done && !rd_match && at_top;
   assign retry    = rd_done && !rd_match && !at_top;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         tap     <= '0;
         run_cnt <= '0;
         fail_q  <= 1'b0;
      end else begin
         if (inc)
            tap <= tap + 1'b1;
         if (rd_done)
            run_cnt <= rd_match ? run_cnt + 1'b1 : '0;
         if (fail)
            fail_q <= 1'b1;
      end
   end

endmodule

// File: rtl/rdcal_status.sv
module rdcal_status #(
   parameter int LANES  = 4,
   parameter int LANE_W = 2,
   parameter int TAP_W  = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   wr,
   input  logic [LANE_W-1:0]      lane,
   input  logic                   slip,
   input  logic [TAP_W-1:0]       tap,
   input  logic                   fail,
   output logic [LANES-1:0]       st_slip,
   output logic [LANES*TAP_W-1:0] st_tap,
   output logic [LANES-1:0]       st_fail
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            st_slip[i]              <= 1'b0;
            st_tap[i*TAP_W +: TAP_W] <= '0;
            st_fail[i]              <= 1'b0;
         end else if (wr && lane == LANE_W'(i)) begin
            st_slip[i]              <= slip;
            st_tap[i*TAP_W +: TAP_W] <= tap;
            st_fail[i]              <= fail;
         end
      end
   end

endmodule

// File: rtl/rdcal_ctrl.sv
module rdcal_ctrl
   import rdcal_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int TAP_W     = 5,
   parameter int CONSIST_N = 16
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  start,
   output logic                                  fill_req,
   input  logic                                  fill_ack,
   output logic [idx_bits(LANES)-1:0]            lane_sel,
   output logic                                  dly_rst,
   input  logic                                  lvl_sample,
   output logic                                  dqs_req,
   input  logic                                  dqs_ack,
   output logic                                  slip_req,
   input  logic                                  slip_ack,
   output logic                                  dly_inc,
   output logic                                  rd_req,
   input  logic                                  rd_ack,
   input  logic                                  rd_match,
   output logic                                  busy,
   output logic                                  done,
   output logic [LANES-1:0]                      lane_slip,
   output logic [LANES*TAP_W-1:0]                lane_tap,
   output logic [LANES-1:0]                      lane_fail
);

   localparam int LANE_W = idx_bits(LANES);
   localparam int CNT_W  = idx_bits(CONSIST_N);

   if (LANES < 1) begin : g_bad_lanes
      $error("rdcal_ctrl: LANES must be at least 1");
   end
   if (TAP_W < 1 || TAP_W > 16) begin : g_bad_tap
      $error("rdcal_ctrl: TAP_W must be within 1..16");
   end
   if (CONSIST_N < 2) begin : g_bad_run
      $error("rdcal_ctrl: CONSIST_N must be at least 2");
   end

   cal_st_e          st;
   logic [LANE_W-1:0] lane;
   logic             slip_used;
   logic [TAP_W-1:0] tap;
   logic             fail_q;
   logic             sw_pass, sw_fail, sw_retry;
   logic             rd_done;

   assign rd_done = rd_req && rd_ack;

   rdcal_seq #(.LANES(LANES), .LANE_W(LANE_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .fill_ack   (fill_ack),
      .lvl_sample (lvl_sample),
      .dqs_ack    (dqs_ack),
      .slip_ack   (slip_ack),
      .sw_pass    (sw_pass),
      .sw_fail    (sw_fail),
      .sw_retry   (sw_retry),
      .st         (st),
      .lane       (lane),
      .slip_used  (slip_used)
   );

   rdcal_sweep #(.TAP_W(TAP_W), .CONSIST_N(CONSIST_N), .CNT_W(CNT_W)) u_sweep (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (st == ST_RST),
      .inc      (st == ST_INC),
      .rd_done  (rd_done),
      .rd_match (rd_match),
      .tap      (tap),
      .fail_q   (fail_q),
      .pass     (sw_pass),
      .fail     (sw_fail),
      .retry    (sw_retry)
   );

   rdcal_status #(.LANES(LANES), .LANE_W(LANE_W), .TAP_W(TAP_W)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (st == ST_IDLE && start),
      .wr      (st == ST_NEXT),
      .lane    (lane),
      .slip    (slip_used),
      .tap     (tap),
      .fail    (fail_q),
      .st_slip (lane_slip),
      .st_tap  (lane_tap),
      .st_fail (lane_fail)
   );

   assign lane_sel = lane;
   assign fill_req = (st == ST_FILL);
   assign dly_rst  = (st == ST_RST);
   assign dqs_req  = (st == ST_DQSMV);
   assign slip_req = (st == ST_SLIP);
   assign rd_req   = (st == ST_READ);
   assign dly_inc  = (st == ST_INC);
   assign done     = (st == ST_DONE);
   assign busy     = (st != ST_IDLE);

endmodule

// File: rtl/rdcal_chk.sv
module rdcal_chk #(
   parameter int TAP_W = 5
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic fill_req,
   input logic dly_rst,
   input logic dqs_req,
   input logic slip_req,
   input logic dly_inc,
   input logic rd_req,
   input logic done
);

   localparam int TOP = (1 << TAP_W) - 1;

   logic [TAP_W:0] inc_seen;

   always_ff @(posedge clk) begin
      if (!rst_n || dly_rst) inc_seen <= '0;
      else if (dly_inc)      inc_seen <= inc_seen + 1'b1;
   end

   assert_one_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fill_req, dly_rst, dqs_req, slip_req, rd_req, dly_inc, done}));

   assert_fill_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fill_req) |-> $past(start) && !$past(busy));

   assert_rst_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dly_rst |=> !dly_rst);

   assert_slip_after_dqs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slip_req) |-> $past(dqs_req));

   assert_inc_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dly_inc |=> rd_req);

   assert_inc_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dly_inc |-> (inc_seen < (TAP_W+1)'(TOP)));

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy && !done);

endmodule

bind rdcal_ctrl rdcal_chk #(.TAP_W(TAP_W)) u_rdcal_chk (.*);

// File: tb/rdcal_ctrl_bench.sv
module rdcal_ctrl_bench;

   localparam int LANES = 4;
   localparam int TAP_W = 5;
   localparam int CN    = 16;
   localparam int TOP   = 31;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, start, fill_req, fill_ack, dly_rst, lvl_sample;
   logic dqs_req, dqs_ack, slip_req, slip_ack, dly_inc, rd_req, rd_ack, rd_match;
   logic busy, done;
   logic [1:0] lane_sel;
   logic [LANES-1:0] lane_slip, lane_fail;
   logic [LANES*TAP_W-1:0] lane_tap;

   rdcal_ctrl #(.LANES(LANES), .TAP_W(TAP_W), .CONSIST_N(CN)) u_rdcal_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .fill_req(fill_req), .fill_ack(fill_ack), .lane_sel(lane_sel),
      .dly_rst(dly_rst), .lvl_sample(lvl_sample),
      .dqs_req(dqs_req), .dqs_ack(dqs_ack),
      .slip_req(slip_req), .slip_ack(slip_ack),
      .dly_inc(dly_inc), .rd_req(rd_req), .rd_ack(rd_ack), .rd_match(rd_match),
      .busy(busy), .done(done),
      .lane_slip(lane_slip), .lane_tap(lane_tap), .lane_fail(lane_fail)
   );

   int errors = 0;
   int checks = 0;
   int q[$];
   bit lvl_cfg[LANES];
   int good_cfg[LANES];
   int glitch_cfg[LANES];
   int exp_tap[LANES];
   bit exp_fail[LANES];
   int cur_tap, rd_idx, wcnt, tick, dones, cyc;
   bit glitch_used, lvl_hold;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   function automatic int ev(input int ty, input int l, input int v);
      return ty * 10000 + l * 100 + v;
   endfunction

   function automatic string tag_of(input int e);
      case (e / 10000)
         1: return "R3";
         2, 3: return "R4";
         4: return "R6";
         5, 6: return "R5";
         7: return "R2";
         default: return "R9";
      endcase
   endfunction

   task automatic log_ev(input int e);
      int x;
      if (q.size() == 0) begin
         check(1'b0, tag_of(e), "unexpected event", e, -1);
      end else begin
         x = q.pop_front();
         check(e == x, tag_of(x), "event order", e, x);
      end
   endtask

   // reference: expected event list of a whole pass
   task automatic plan_run();
      q.delete();
      q.push_back(ev(7, 0, 0));
      for (int l = 0; l < LANES; l++) begin
         int t;
         bit used, fin;
         t = 0; used = 0; fin = 0;
         q.push_back(ev(1, l, 0));
         if (lvl_cfg[l]) begin
            q.push_back(ev(2, l, 0));
            q.push_back(ev(3, l, 0));
         end
         while (!fin) begin
            if (t >= good_cfg[l] && !(t == good_cfg[l] && glitch_cfg[l] >= 0 && !used)) begin
               for (int k = 0; k < CN; k++) q.push_back(ev(6, l, t));
               exp_tap[l] = t; exp_fail[l] = 0; fin = 1;
            end else begin
               if (t >= good_cfg[l]) begin
                  for (int k = 0; k < glitch_cfg[l]; k++) q.push_back(ev(6, l, t));
                  used = 1;
               end
               q.push_back(ev(5, l, t));
               if (t == TOP) begin
                  exp_tap[l] = TOP; exp_fail[l] = 1; fin = 1;
               end else begin
                  t++;
                  q.push_back(ev(4, l, t));
               end
            end
         end
      end
      q.push_back(ev(8, 0, 0));
   endtask

   // responder and event monitor, all on the falling edge
   always @(negedge clk) begin
      int ln, dly;
      bit m;
      if (!rst_n) begin
         fill_ack = 0; dqs_ack = 0; slip_ack = 0; rd_ack = 0; rd_match = 0;
         lvl_sample = 0; wcnt = 0; cur_tap = 0; rd_idx = 0; glitch_used = 0;
         lvl_hold = 0; dones = 0;
      end else begin
         ln = int'(lane_sel);
         dly = tick % 3;
         fill_ack = 0; dqs_ack = 0; slip_ack = 0; rd_ack = 0;
         rd_match = tick[1];
         check($countones({fill_req, dly_rst, dqs_req, slip_req, rd_req, dly_inc, done}) <= 1,
               "R10", "outputs active together", 2, 1);
         if (dly_rst) begin
            log_ev(ev(1, ln, 0));
            cur_tap = 0; rd_idx = 0; glitch_used = 0;
            lvl_sample = lvl_cfg[ln]; lvl_hold = 1;
         end else if (lvl_hold) begin
            lvl_hold = 0;
         end else begin
            lvl_sample = tick[0];
         end
         if (dly_inc) begin
            cur_tap++; rd_idx = 0;
            log_ev(ev(4, ln, cur_tap));
         end
         if (done) begin
            log_ev(ev(8, 0, 0));
            dones++;
         end
         if (fill_req || dqs_req || slip_req) begin
            if (wcnt >= dly) begin
               wcnt = 0;
               if (fill_req) begin fill_ack = 1; log_ev(ev(7, 0, 0)); end
               if (dqs_req)  begin dqs_ack = 1;  log_ev(ev(2, ln, 0)); end
               if (slip_req) begin slip_ack = 1; log_ev(ev(3, ln, 0)); end
            end else wcnt++;
         end
         if (rd_req && (tick % 4 != 0)) begin
            m = (cur_tap >= good_cfg[ln]);
            if (cur_tap == good_cfg[ln] && glitch_cfg[ln] >= 0 && !glitch_used
                && rd_idx == glitch_cfg[ln]) begin
               m = 0; glitch_used = 1;
            end
            rd_ack = 1; rd_match = m; rd_idx++;
            log_ev(ev(m ? 6 : 5, ln, cur_tap));
         end
      end
      tick++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         check(1'b0, "R9", "watchdog expired", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check_status();
      for (int l = 0; l < LANES; l++) begin
         check(lane_slip[l] == lvl_cfg[l], "R4", $sformatf("lane %0d slip flag", l),
               int'(lane_slip[l]), int'(lvl_cfg[l]));
         check(int'(lane_tap[l*TAP_W +: TAP_W]) == exp_tap[l], "R8",
               $sformatf("lane %0d final tap", l), int'(lane_tap[l*TAP_W +: TAP_W]), exp_tap[l]);
         check(lane_fail[l] == exp_fail[l], "R7", $sformatf("lane %0d fail flag", l),
               int'(lane_fail[l]), int'(exp_fail[l]));
      end
   endtask

   task automatic run_pass(input bit poke_busy);
      int d0;
      plan_run();
      d0 = dones;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
      check(lane_slip == '0 && lane_tap == '0 && lane_fail == '0, "R8",
            "status cleared on start", int'(lane_tap), 0);
      if (poke_busy) begin
         repeat (20) @(negedge clk);
         start = 1;
         @(negedge clk) start = 0;
      end
      while (dones == d0) @(negedge clk);
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R9", "idle after done", int'(busy), 0);
      check(q.size() == 0, "R9", "events left over", q.size(), 0);
      check_status();
      repeat (5) @(negedge clk);
      check(lane_tap[TAP_W-1:0] == TAP_W'(exp_tap[0]), "R8", "status held", int'(lane_tap[TAP_W-1:0]), exp_tap[0]);
   endtask

   initial begin
      cyc = 0; tick = 0;
      rst_n = 0; start = 0;
      repeat (3) @(negedge clk);
      check({fill_req, dly_rst, dqs_req, slip_req, rd_req, dly_inc, done, busy} == '0,
            "R1", "outputs in reset", 1, 0);
      check(lane_slip == '0 && lane_tap == '0 && lane_fail == '0, "R1",
            "status in reset", int'(lane_tap), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      check(busy == 1'b0 && fill_req == 1'b0, "R1", "idle after reset", int'(busy), 0);

      // pass 1: plain lane, glitching lane with bitslip, failing lane, late good lane
      lvl_cfg    = '{0, 1, 0, 1};
      good_cfg   = '{3, 0, 40, 7};
      glitch_cfg = '{-1, 5, -1, -1};
      run_pass(1'b1);

      // pass 2: pass at the top tap, immediate pass, glitch at first read, fail with slip
      lvl_cfg    = '{1, 0, 0, 1};
      good_cfg   = '{31, 0, 2, 40};
      glitch_cfg = '{-1, -1, 0, -1};
      run_pass(1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule